// File: doc/BRIEF.md
# Floppy Drive Control Register Port

This block stands in for the control side of a floppy drive as seen by a host computer. The host presents a four-bit select code and samples one read line. It pulses a write strobe to change drive state. The read line always shows the one-bit status chosen by the select code. The path from the select code to the read line is purely combinational, so the host gets its answer within a few of its own CPU clocks and needs no handshake.

Writes borrow the top select line as the data bit. The lower three select lines name the control target. A rising edge of the strobe, seen through a synchronizer in the block's fast clock domain, stores that bit into the named target. A step request moves a head-position counter one track in the latched direction. The counter is held within the drive's track range. A short stepping window follows each step, and further step requests are ignored while it is open.

A companion microcontroller drives the write-protect and disk-present status bits. It reads back the motor, eject and track state on a sideband.

Top module: `drive_regport`

## Requirements
- R1: While reset is held and after it is released, motor, eject, step direction and the stepping flag are 0 and the track is 0.
- R2: host_rd is a combinational function of host_sel. Read codes: 4'h1 stepping flag, 4'h2 motor, 4'h4 track-zero, 4'h5 write-protect, 4'h6 disk present. Every other code reads 1.
- R3: A rising strobe edge commits exactly one write. The data bit is host_sel[3] and the target is host_sel[2:0]. A pulse two clocks long is not lost, and a strobe held high does not write again.
- R4: Write targets: 3'd0 step direction (1 = toward higher tracks), 3'd2 motor, 3'd3 eject. A write to targets 3'd4 through 3'd7 changes nothing.
- R5: A write of 1 to target 3'd1 is a step request. It moves the track one step in the latched direction.
- R6: The track stays within 0 to TRACK_MAX (79). A step past either end leaves the track unchanged.
- R7: An accepted step raises the stepping flag for STEP_HOLD (8) clocks. Step requests that arrive while the flag is set are ignored.
- R8: A write of 0 to target 3'd1 does not step and does not raise the stepping flag.
- R9: Track-zero reads 1 exactly when the track is 0. Write-protect and disk present read back the sideband inputs unchanged.
- R10: The sideband outputs show the latched motor and eject bits and the current track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, fast relative to the host strobe |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sel | input | 4 | Host select code; bit 3 carries write data |
| host_wstrb | input | 1 | Host write strobe, asynchronous |
| host_rd | output | 1 | Selected status bit |
| mcu_wprot | input | 1 | Write-protect status from the microcontroller |
| mcu_disk_in | input | 1 | Disk-present status from the microcontroller |
| mcu_motor_on | output | 1 | Latched motor bit |
| mcu_eject | output | 1 | Latched eject bit |
| mcu_track | output | 7 | Current head track |

## Verification
host_rd depends only on the present inputs and state, so the bench changes host_sel on a falling edge and samples 1 ns later. A write commits on the third rising clock edge after the strobe rises: two synchronizer stages and then the register. The bench holds the select code for five falling edges around each pulse and reads the outputs only after that. The stepping flag rises on the same edge as the step commit and stays up for STEP_HOLD clocks. The bench reads it right after a step and again after waiting more than STEP_HOLD clocks. It issues a second step request about five clocks after the first, which falls inside the window.

// File: rtl/fdreg_pkg.sv
package fdreg_pkg;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = SEL_W - 1;
  localparam int NCODES = 1 << SEL_W;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // write targets, decoded from the low select bits
  localparam addr_t WR_DIR   = 3'd0;
  localparam addr_t WR_STEP  = 3'd1;
  localparam addr_t WR_MOTOR = 3'd2;
  localparam addr_t WR_EJECT = 3'd3;

  // read targets, decoded from the full select code
  localparam sel_t RD_STEPPING = 4'h1;
  localparam sel_t RD_MOTOR    = 4'h2;
  localparam sel_t RD_TRK0     = 4'h4;
  localparam sel_t RD_WPROT    = 4'h5;
  localparam sel_t RD_DISKIN   = 4'h6;

  typedef struct packed {
    logic  valid;
    addr_t addr;
    logic  data;
  } wr_cmd_t;

  typedef struct packed {
    logic dir;
    logic motor;
    logic eject;
  } ctrl_t;
endpackage

// File: rtl/regport_rst_sync.sv
module regport_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= 2'b00;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/regport_wr_sync.sv
module regport_wr_sync
  import fdreg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  sel_t    sel_i,
  input  logic    strobe_i,
  output wr_cmd_t cmd_o
);
  logic [STAGES-1:0] strb_q;
  sel_t              sel_q [STAGES];
  logic              strb_last_q;
  logic              strb_last_d;

  // synchronizer chain; select bits travel beside the strobe
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic strb_d;
    sel_t sel_d;
    if (s == 0) begin : g_first
      assign strb_d = strobe_i;
      assign sel_d  = sel_i;
    end else begin : g_next
      assign strb_d = strb_q[s-1];
      assign sel_d  = sel_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        strb_q[s] <= 1'b0;
        sel_q[s]  <= '0;
      end else begin
        strb_q[s] <= strb_d;
        sel_q[s]  <= sel_d;
      end
    end
  end

  always_comb begin
    strb_last_d = strb_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_last_q <= 1'b0;
    else        strb_last_q <= strb_last_d;
  end

  always_comb begin
    cmd_o.valid = strb_q[STAGES-1] & ~strb_last_q;
    cmd_o.addr  = sel_q[STAGES-1][ADDR_W-1:0];
    cmd_o.data  = sel_q[STAGES-1][SEL_W-1];
  end
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import fdreg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_cmd_t cmd_i,
  output ctrl_t   ctrl_o,
  output logic    step_req_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (cmd_i.valid) begin
      unique case (cmd_i.addr)
        WR_DIR:   begin ctrl_d.dir   = cmd_i.data; ctrl_en = 1'b1; end
        WR_MOTOR: begin ctrl_d.motor = cmd_i.data; ctrl_en = 1'b1; end
        WR_EJECT: begin ctrl_d.eject = cmd_i.data; ctrl_en = 1'b1; end
        default:  ctrl_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o     = ctrl_q;
  assign step_req_o = cmd_i.valid && (cmd_i.addr == WR_STEP) && cmd_i.data;
endmodule

// File: rtl/regport_head.sv
module regport_head #(
  parameter int TRACK_MAX = 79,
  parameter int STEP_HOLD = 8,
  parameter int TRK_W     = $clog2(TRACK_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req_i,
  input  logic             dir_i,
  output logic [TRK_W-1:0] track_o,
  output logic             busy_o
);
  localparam int BW = $clog2(STEP_HOLD + 1);
  localparam logic [TRK_W-1:0] TMAX  = TRK_W'(TRACK_MAX);
  localparam logic [BW-1:0]    THOLD = BW'(STEP_HOLD);

  logic [TRK_W-1:0] track_q, track_d;
  logic [BW-1:0]    cnt_q, cnt_d;
  logic             accept;
  logic             trk_en;

  always_comb begin
    accept  = step_req_i && (cnt_q == '0);
    track_d = track_q;
    trk_en  = 1'b0;
    if (accept) begin
      if (dir_i && (track_q < TMAX)) begin
        track_d = track_q + 1'b1;
        trk_en  = 1'b1;
      end else if (!dir_i && (track_q != '0)) begin
        track_d = track_q - 1'b1;
        trk_en  = 1'b1;
      end
    end
    if (accept)            cnt_d = THOLD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      track_q <= '0;
    else if (trk_en) track_q <= track_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign track_o = track_q;
  assign busy_o  = (cnt_q != '0);
endmodule

// File: rtl/regport_rd_mux.sv
module regport_rd_mux
  import fdreg_pkg::*;
(
  input  sel_t sel_i,
  input  logic stepping_i,
  input  logic motor_i,
  input  logic trk0_i,
  input  logic wprot_i,
  input  logic diskin_i,
  output logic rd_o
);
  logic [NCODES-1:0] vec;

  for (genvar k = 0; k < NCODES; k++) begin : g_code
    if (sel_t'(k) == RD_STEPPING)    begin : g_stp assign vec[k] = stepping_i; end
    else if (sel_t'(k) == RD_MOTOR)  begin : g_mot assign vec[k] = motor_i;    end
    else if (sel_t'(k) == RD_TRK0)   begin : g_tk0 assign vec[k] = trk0_i;     end
    else if (sel_t'(k) == RD_WPROT)  begin : g_wp  assign vec[k] = wprot_i;    end
    else if (sel_t'(k) == RD_DISKIN) begin : g_din assign vec[k] = diskin_i;   end
    else                             begin : g_one assign vec[k] = 1'b1;       end
  end

  assign rd_o = vec[sel_i];
endmodule

// File: rtl/drive_regport.sv
module drive_regport
  import fdreg_pkg::*;
#(
  parameter int TRACK_MAX   = 79,
  parameter int STEP_HOLD   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TRK_W      = $clog2(TRACK_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       host_sel,
  input  logic             host_wstrb,
  output logic             host_rd,
  input  logic             mcu_wprot,
  input  logic             mcu_disk_in,
  output logic             mcu_motor_on,
  output logic             mcu_eject,
  output logic [TRK_W-1:0] mcu_track
);
  logic             rst_n_s;
  wr_cmd_t          wr_cmd;
  logic             wr_commit;
  ctrl_t            ctrl;
  logic             step_req;
  logic             step_busy;
  logic [TRK_W-1:0] track;

  regport_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  regport_wr_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sel_i    (host_sel),
    .strobe_i (host_wstrb),
    .cmd_o    (wr_cmd)
  );

  assign wr_commit = wr_cmd.valid;

  regport_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cmd_i      (wr_cmd),
    .ctrl_o     (ctrl),
    .step_req_o (step_req)
  );

  regport_head #(
    .TRACK_MAX (TRACK_MAX),
    .STEP_HOLD (STEP_HOLD),
    .TRK_W     (TRK_W)
  ) u_head (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .step_req_i (step_req),
    .dir_i      (ctrl.dir),
    .track_o    (track),
    .busy_o     (step_busy)
  );

  regport_rd_mux u_rmux (
    .sel_i      (host_sel),
    .stepping_i (step_busy),
    .motor_i    (ctrl.motor),
    .trk0_i     (track == '0),
    .wprot_i    (mcu_wprot),
    .diskin_i   (mcu_disk_in),
    .rd_o       (host_rd)
  );

  assign mcu_motor_on = ctrl.motor;
  assign mcu_eject    = ctrl.eject;
  assign mcu_track    = track;
endmodule

// File: rtl/drive_regport_chk.sv
module drive_regport_chk #(
  parameter int TRACK_MAX = 79,
  parameter int TRK_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       host_sel,
  input logic             host_rd,
  input logic             mcu_wprot,
  input logic             mcu_disk_in,
  input logic             mcu_motor_on,
  input logic             mcu_eject,
  input logic [TRK_W-1:0] mcu_track,
  input logic             commit,
  input logic             busy
);
  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> ($stable(mcu_motor_on) && $stable(mcu_eject)));

  p_track_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_track != $past(mcu_track)) |->
      ((mcu_track == $past(mcu_track) + 1'b1) || (mcu_track + 1'b1 == $past(mcu_track))));

  p_track_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_track <= TRK_W'(TRACK_MAX));

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(mcu_track));

  p_trk0_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 4'h4) |-> (host_rd == (mcu_track == '0)));

  p_status_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 4'h5) |-> (host_rd == mcu_wprot));

  p_disk_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 4'h6) |-> (host_rd == mcu_disk_in));

  p_unused_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 4'h0 || host_sel == 4'h3 || host_sel >= 4'h7) |-> host_rd);
endmodule

bind drive_regport drive_regport_chk #(
  .TRACK_MAX (TRACK_MAX),
  .TRK_W     (TRK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_sel     (host_sel),
  .host_rd      (host_rd),
  .mcu_wprot    (mcu_wprot),
  .mcu_disk_in  (mcu_disk_in),
  .mcu_motor_on (mcu_motor_on),
  .mcu_eject    (mcu_eject),
  .mcu_track    (mcu_track),
  .commit       (wr_commit),
  .busy         (step_busy)
);

// File: tb/drive_regport_bench.sv
module drive_regport_bench;
  localparam int TMAX = 79;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] host_sel;
  logic       host_wstrb;
  logic       host_rd;
  logic       mcu_wprot;
  logic       mcu_disk_in;
  logic       mcu_motor_on;
  logic       mcu_eject;
  logic [6:0] mcu_track;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_trk;

  always #10 clk = ~clk;

  drive_regport u_drive_regport (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_wstrb   (host_wstrb),
    .host_rd      (host_rd),
    .mcu_wprot    (mcu_wprot),
    .mcu_disk_in  (mcu_disk_in),
    .mcu_motor_on (mcu_motor_on),
    .mcu_eject    (mcu_eject),
    .mcu_track    (mcu_track)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_code(input logic [3:0] code, output logic val);
    @(negedge clk);
    host_sel = code;
    #1 val = host_rd;
  endtask

  // strobe high for two clocks; commit lands on the third rising edge
  task automatic do_write(input logic [2:0] tgt, input logic dat);
    @(negedge clk);
    host_sel   = {dat, tgt};
    host_wstrb = 1'b1;
    repeat (2) @(negedge clk);
    host_wstrb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_read(input int code, input int stp, input int mot,
                                  input int trk, input int wp, input int di);
    case (code)
      1: return stp;
      2: return mot;
      4: return (trk == 0) ? 1 : 0;
      5: return wp;
      6: return di;
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v;
    rst_n = 1'b0; host_sel = 4'h0; host_wstrb = 1'b0;
    mcu_wprot = 1'b0; mcu_disk_in = 1'b0;
    idle(4);
    // R1: state while reset is held
    check("R1 motor in reset", mcu_motor_on, 0);
    check("R1 eject in reset", mcu_eject, 0);
    check("R1 track in reset", mcu_track, 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 motor after reset", mcu_motor_on, 0);
    check("R1 track after reset", mcu_track, 0);

    // R2 R9: sweep every code under every status combination
    for (int s = 0; s < 4; s++) begin
      mcu_wprot   = s[0];
      mcu_disk_in = s[1];
      for (int c = 0; c < 16; c++) begin
        read_code(c[3:0], v);
        check("R2/R9 read sweep", v, exp_read(c, 0, 0, 0, s[0], s[1]));
      end
    end
    mcu_wprot = 1'b1; mcu_disk_in = 1'b0;

    // R4 R10: motor and eject targets
    do_write(3'd2, 1'b1);
    check("R4 motor set", mcu_motor_on, 1);
    read_code(4'h2, v);
    check("R10 motor read", v, 1);
    do_write(3'd3, 1'b1);
    check("R4 eject set", mcu_eject, 1);
    do_write(3'd3, 1'b0);
    check("R4 eject clear", mcu_eject, 0);
    check("R10 motor kept", mcu_motor_on, 1);

    // R4: targets 4..7 change nothing
    for (int t = 4; t < 8; t++) begin
      do_write(t[2:0], 1'b1);
      check("R4 unused target motor", mcu_motor_on, 1);
      check("R4 unused target eject", mcu_eject, 0);
      check("R4 unused target track", mcu_track, 0);
      read_code(4'h1, v);
      check("R4 unused target stepping", v, 0);
    end

    // R8: step target with data 0
    do_write(3'd1, 1'b0);
    read_code(4'h1, v);
    check("R8 no stepping flag", v, 0);
    check("R8 no step", mcu_track, 0);

    // R6: step outward at track 0 is clamped
    do_write(3'd0, 1'b0);
    do_write(3'd1, 1'b1);
    idle(HOLD + 2);
    check("R6 clamp at zero", mcu_track, 0);

    // R5 R6 R7 R9: sweep up past the top
    do_write(3'd0, 1'b1);
    exp_trk = 0;
    for (int i = 0; i < TMAX + 5; i++) begin
      do_write(3'd1, 1'b1);
      if (exp_trk < TMAX) exp_trk++;
      check("R5/R6 step inward", mcu_track, exp_trk);
      read_code(4'h1, v);
      check("R7 stepping raised", v, 1);
      idle(HOLD + 1);
      read_code(4'h1, v);
      check("R7 stepping cleared", v, 0);
      read_code(4'h4, v);
      check("R9 track zero flag", v, 0);
    end

    // R7: second request inside the window is ignored
    do_write(3'd0, 1'b0);
    do_write(3'd1, 1'b1);
    do_write(3'd1, 1'b1);
    idle(HOLD + 2);
    check("R7 request in window ignored", mcu_track, TMAX - 1);
    exp_trk = TMAX - 1;

    // R3: strobe held high commits once
    @(negedge clk);
    host_sel = 4'b1001;
    host_wstrb = 1'b1;
    idle(3 * HOLD);
    host_wstrb = 1'b0;
    idle(3);
    exp_trk--;
    check("R3 held strobe single step", mcu_track, exp_trk);
    idle(HOLD);

    // R5 R6 R9: sweep down past zero
    for (int i = 0; i < TMAX + 3; i++) begin
      do_write(3'd1, 1'b1);
      if (exp_trk > 0) exp_trk--;
      check("R5/R6 step outward", mcu_track, exp_trk);
      idle(HOLD + 1);
      read_code(4'h4, v);
      check("R9 track zero flag", v, (exp_trk == 0) ? 1 : 0);
    end
    read_code(4'h5, v);
    check("R9 write protect read", v, 1);
    check("R10 motor sideband", mcu_motor_on, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule